// File: doc/BRIEF.md
# Multi-Mode Up/Down Timer with Reload Bank

This block is a counter of configurable width (32 bits by default). It moves by one step each time a single-cycle `tick` pulse arrives while it is enabled and started. It can count up, count down, or bounce between zero and all-ones as a triangle. Five operating modes cover the common uses. The counter can run freely, stop at a terminal value or a match value, or jump to a reload value at either of those points and keep running. Four reload registers form a small bank. The active entry is chosen by an index that software writes and that can also step forward or backward by itself on every match, so a sequence of different periods can be set up once and then replayed without further writes.

A surrounding bus wrapper owns the register decoding and drives this block's configuration levels and one-cycle strobes directly. The block reports the count, a run flag, a reset-held flag, the active reload index, three sticky event flags, one interrupt line and three one-cycle trigger lines for downstream peripherals.

Top module: `span_timer`

## Requirements
- R1: After `rst_n` is low, `count` is 0, all flags are 0, `idx_now` is 0, `run` and `in_reset` are 0, and `irq` and all trigger lines are 0.
- R2: `run` is 1 exactly when `ctl_en` is 1, the start state is set and `in_reset` is 0. `start_set` sets the start state and `start_clr` clears it. `count` takes one step on a clock edge only when `tick` and `run` are both 1 and neither `soft_rst` nor `cnt_wr` is present in that cycle. `cnt_wr` loads `cnt_wdata` directly.
- R3: With `dir_sel`=0 the count goes up by one per step and wraps from all-ones to 0. That wrapping step sets `flag_over`.
- R4: With `dir_sel`=1 the count goes down by one per step and wraps from 0 to all-ones. That wrapping step sets `flag_under`.
- R5: With `dir_sel`=2 the count goes up until it reaches all-ones and then down until it reaches 0, and repeats. The step arriving at all-ones sets `flag_over` and reverses the direction; the step arriving at 0 sets `flag_under` and reverses the direction. `cnt_wr` leaves the current direction unchanged, and `soft_rst` makes it upward.
- R6: With `mode_sel`=1, a step whose result is the terminal value ends the run. The terminal value is all-ones for direction 0, 0 for direction 1, and either end for direction 2. The count holds that value and the start state clears, so `run` drops.
- R7: With `mode_sel`=2, a step whose result equals `match_val` ends the run in the same way.
- R8: With `mode_sel`=3, a step whose result would be the terminal value loads the active reload register instead. Counting continues from there.
- R9: With `mode_sel`=4, a step whose result would equal `match_val` loads the active reload register instead. Counting continues from there.
- R10: A match is a step whose result equals `match_val`. On each match, `idx_policy` acts on `idx_now`: code 0 keeps it, code 1 adds one modulo 4, and code 2 subtracts one modulo 4. A reload on that same step uses the index value from before the step. `idx_wr` loads `idx_wdata` and takes priority.
- R11: `flag_match`, `flag_under` and `flag_over` stay set until cleared. Writing 1 to `flag_clr` bit 0, 1 or 2 respectively clears them. An event in the same cycle as a clear leaves the flag set.
- R12: `soft_rst` forces `count` to 0 on the next edge. `in_reset` is 1 in each cycle that follows a cycle with `soft_rst` high, and no step happens while `in_reset` is 1.
- R13: `irq` is `irq_en` ANDed with the flag that `irq_cause` selects: 0 selects match, 1 selects underflow, 2 selects overflow. Any other code gives 0.
- R14: On a step that is the mode's trigger event, exactly one trigger line pulses for one cycle after the edge. The trigger event is a wrap or turn-around for mode 0, the terminal value for modes 1 and 3, and a match for modes 2 and 4. `trig_route` chooses the line: 0 is none, 1 is `trig_dma1`, 2 is `trig_dma2`, 3 is `trig_uart`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle count-enable pulse |
| ctl_en | input | 1 | Timer enable level |
| start_set | input | 1 | Strobe: set start state |
| start_clr | input | 1 | Strobe: clear start state |
| soft_rst | input | 1 | Soft reset, clears count while high |
| dir_sel | input | 2 | Direction: 0 up, 1 down, 2 triangle |
| mode_sel | input | 3 | Operating mode 0..4 |
| match_val | input | WIDTH | Compare value |
| cnt_wr | input | 1 | Strobe: load count |
| cnt_wdata | input | WIDTH | Count load value |
| rld_wr | input | 1 | Strobe: write a reload register |
| rld_addr | input | IDXW | Reload register number for writes |
| rld_wdata | input | WIDTH | Reload register write data |
| idx_wr | input | 1 | Strobe: set active reload index |
| idx_wdata | input | IDXW | New active reload index |
| idx_policy | input | 2 | Index action on match: 0 keep, 1 up, 2 down |
| flag_clr | input | 3 | Write-1-to-clear: bit0 match, bit1 under, bit2 over |
| irq_en | input | 1 | Interrupt enable |
| irq_cause | input | 3 | Interrupt source select |
| trig_route | input | 2 | Trigger line select |
| count | output | WIDTH | Current count |
| run | output | 1 | Counter is actually running |
| in_reset | output | 1 | Timer held in soft reset |
| idx_now | output | IDXW | Active reload index |
| flag_match | output | 1 | Sticky match flag |
| flag_under | output | 1 | Sticky underflow flag |
| flag_over | output | 1 | Sticky overflow flag |
| irq | output | 1 | Interrupt line |
| trig_dma1 | output | 1 | Trigger pulse, first DMA channel |
| trig_dma2 | output | 1 | Trigger pulse, second DMA channel |
| trig_uart | output | 1 | Trigger pulse, UART |

## Verification
The bench sweeps every direction against every mode. Each run starts a few steps short of the boundary and is interrupted by enable gaps, restarts, count loads, index writes and flag clears. Every output is compared in every cycle against an arithmetic model.

The turn-around points of the triangle are targeted directly. A design that reversed one step late would show all-ones twice or wrap to zero. A design that flagged on the departing step would raise the overflow or underflow flag one step off.

Reload modes are watched for the replaced step. An off-by-one design would show the terminal or match value for a cycle before the reload. Advancing the index before the reload would pick the wrong bank entry.

Single-shot modes are checked for the run flag dropping on exactly the stopping step, and for holding the stop value until a restart.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  typedef enum logic [1:0] {
    DIR_UP   = 2'd0,
    DIR_DOWN = 2'd1,
    DIR_TRI  = 2'd2,
    DIR_RSV  = 2'd3
  } tmr_dir_e;

  typedef enum logic [2:0] {
    MD_FREE      = 3'd0,
    MD_ONE_END   = 3'd1,
    MD_ONE_MATCH = 3'd2,
    MD_RLD_END   = 3'd3,
    MD_RLD_MATCH = 3'd4
  } tmr_mode_e;

  // Triangle heading: leave an end in the only legal direction, else keep heading.
  function automatic logic tri_heads_up(logic phase_up, logic at_top, logic at_bottom);
    return at_bottom | (phase_up & ~at_top);
  endfunction

  // Heading after a triangle step, derived from where the step landed.
  function automatic logic tri_phase_after(logic went_up, logic land_top, logic land_bottom);
    return went_up ? ~land_top : land_bottom;
  endfunction

endpackage

// File: rtl/tmr_step_unit.sv
module tmr_step_unit
  import tmr_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             adv,
  input  logic [WIDTH-1:0] cur,
  input  logic             phase_up,
  input  logic [1:0]       dir,
  input  logic [2:0]       mode,
  input  logic [WIDTH-1:0] match_val,
  input  logic [WIDTH-1:0] reload_val,
  output logic [WIDTH-1:0] nxt_cnt,
  output logic             nxt_phase,
  output logic             ev_ovf,
  output logic             ev_unf,
  output logic             ev_match,
  output logic             ev_term,
  output logic             ev_stop,
  output logic             ev_trig
);

  localparam logic [WIDTH-1:0] ALL1 = '1;
  localparam logic [WIDTH-1:0] ONE  = WIDTH'(1);

  logic             go_up, raw_ovf, raw_unf, arrive, hit, stop_r, trig_r;
  logic [WIDTH-1:0] raw;

  always_comb begin
    raw_ovf   = 1'b0;
    raw_unf   = 1'b0;
    arrive    = 1'b0;
    nxt_phase = phase_up;
    case (dir)
      DIR_DOWN: go_up = 1'b0;
      DIR_TRI:  go_up = tri_heads_up(phase_up, cur == ALL1, cur == '0);
      default:  go_up = 1'b1;
    endcase
    raw = go_up ? cur + ONE : cur - ONE;
    if (dir == DIR_TRI) begin
      raw_ovf   = go_up & (raw == ALL1);
      raw_unf   = ~go_up & (raw == '0);
      arrive    = raw_ovf | raw_unf;
      nxt_phase = tri_phase_after(go_up, raw == ALL1, raw == '0);
    end else if (go_up) begin
      raw_ovf = (cur == ALL1);
      arrive  = (raw == ALL1);
    end else begin
      raw_unf = (cur == '0);
      arrive  = (raw == '0);
    end
    hit     = (raw == match_val);
    stop_r  = 1'b0;
    nxt_cnt = raw;
    case (mode)
      MD_ONE_END:   begin stop_r = arrive; trig_r = arrive; end
      MD_ONE_MATCH: begin stop_r = hit;    trig_r = hit;    end
      MD_RLD_END:   begin trig_r = arrive; if (arrive) nxt_cnt = reload_val; end
      MD_RLD_MATCH: begin trig_r = hit;    if (hit)    nxt_cnt = reload_val; end
      default:      trig_r = raw_ovf | raw_unf;
    endcase
  end

  assign ev_ovf   = adv & raw_ovf;
  assign ev_unf   = adv & raw_unf;
  assign ev_match = adv & hit;
  assign ev_term  = adv & arrive;
  assign ev_stop  = adv & stop_r;
  assign ev_trig  = adv & trig_r;

endmodule

// File: rtl/tmr_reload_bank.sv
module tmr_reload_bank #(
  parameter int WIDTH = 32,
  parameter int NRLD  = 4,
  localparam int IDXW = (NRLD > 1) ? $clog2(NRLD) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [IDXW-1:0]  waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic             idx_wr,
  input  logic [IDXW-1:0]  idx_wdata,
  input  logic [1:0]       policy,
  input  logic             step,
  output logic [IDXW-1:0]  idx,
  output logic [WIDTH-1:0] val
);

  localparam logic [IDXW-1:0] LAST = IDXW'(NRLD - 1);
  localparam logic [IDXW-1:0] UNIT = IDXW'(1);

  logic [WIDTH-1:0] bank [NRLD];

  function automatic logic [IDXW-1:0] idx_after(logic [IDXW-1:0] cur, logic [1:0] pol);
    case (pol)
      2'd1:    return (cur == LAST) ? '0 : cur + UNIT;
      2'd2:    return (cur == '0) ? LAST : cur - UNIT;
      default: return cur;
    endcase
  endfunction

  for (genvar g = 0; g < NRLD; g++) begin : g_entry
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          bank[g] <= '0;
      else if (wr && waddr == IDXW'(g))    bank[g] <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      idx <= '0;
    else if (idx_wr) idx <= idx_wdata;
    else if (step)   idx <= idx_after(idx, policy);
  end

  assign val = bank[idx];

  AST_IDX_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!idx_wr && (!step || policy == 2'd0)) |=> $stable(idx)); // R10

endmodule

// File: rtl/tmr_flag_unit.sv
module tmr_flag_unit (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       set_match,
  input  logic       set_unf,
  input  logic       set_ovf,
  input  logic [2:0] clr,
  input  logic       irq_en,
  input  logic [2:0] irq_cause,
  input  logic       trig_ev,
  input  logic [1:0] route,
  output logic       f_match,
  output logic       f_unf,
  output logic       f_ovf,
  output logic       irq,
  output logic [2:0] trig
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      f_match <= 1'b0;
      f_unf   <= 1'b0;
      f_ovf   <= 1'b0;
    end else begin
      f_match <= set_match | (f_match & ~clr[0]);
      f_unf   <= set_unf   | (f_unf   & ~clr[1]);
      f_ovf   <= set_ovf   | (f_ovf   & ~clr[2]);
    end
  end

  for (genvar k = 0; k < 3; k++) begin : g_trig
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) trig[k] <= 1'b0;
      else        trig[k] <= trig_ev && (route == 2'(k + 1));
    end
  end

  always_comb begin
    case (irq_cause)
      3'd0:    irq = irq_en & f_match;
      3'd1:    irq = irq_en & f_unf;
      3'd2:    irq = irq_en & f_ovf;
      default: irq = 1'b0;
    endcase
  end

  AST_STICKY_OVER: assert property (@(posedge clk) disable iff (!rst_n)
    (f_ovf && !clr[2]) |=> f_ovf); // R11
  AST_ONE_TRIGGER: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(trig)); // R14
  AST_TRIG_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    !trig_ev |=> (trig == 3'b000)); // R14

endmodule

// File: rtl/span_timer.sv
module span_timer
  import tmr_pkg::*;
#(
  parameter int WIDTH = 32,
  parameter int NRLD  = 4,
  localparam int IDXW = (NRLD > 1) ? $clog2(NRLD) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             ctl_en,
  input  logic             start_set,
  input  logic             start_clr,
  input  logic             soft_rst,
  input  logic [1:0]       dir_sel,
  input  logic [2:0]       mode_sel,
  input  logic [WIDTH-1:0] match_val,
  input  logic             cnt_wr,
  input  logic [WIDTH-1:0] cnt_wdata,
  input  logic             rld_wr,
  input  logic [IDXW-1:0]  rld_addr,
  input  logic [WIDTH-1:0] rld_wdata,
  input  logic             idx_wr,
  input  logic [IDXW-1:0]  idx_wdata,
  input  logic [1:0]       idx_policy,
  input  logic [2:0]       flag_clr,
  input  logic             irq_en,
  input  logic [2:0]       irq_cause,
  input  logic [1:0]       trig_route,
  output logic [WIDTH-1:0] count,
  output logic             run,
  output logic             in_reset,
  output logic [IDXW-1:0]  idx_now,
  output logic             flag_match,
  output logic             flag_under,
  output logic             flag_over,
  output logic             irq,
  output logic             trig_dma1,
  output logic             trig_dma2,
  output logic             trig_uart
);

  logic             start_q, phase_q, adv;
  logic [WIDTH-1:0] nxt_cnt, reload_val;
  logic             nxt_phase;
  logic             ev_ovf, ev_unf, ev_match, ev_term, ev_stop, ev_trig;
  logic [2:0]       trig;

  assign run = ctl_en & start_q & ~in_reset;
  assign adv = tick & run & ~soft_rst & ~cnt_wr;

  tmr_step_unit #(.WIDTH(WIDTH)) u_step (
    .adv(adv), .cur(count), .phase_up(phase_q), .dir(dir_sel), .mode(mode_sel),
    .match_val(match_val), .reload_val(reload_val),
    .nxt_cnt(nxt_cnt), .nxt_phase(nxt_phase),
    .ev_ovf(ev_ovf), .ev_unf(ev_unf), .ev_match(ev_match), .ev_term(ev_term),
    .ev_stop(ev_stop), .ev_trig(ev_trig)
  );

  tmr_reload_bank #(.WIDTH(WIDTH), .NRLD(NRLD)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr(rld_wr), .waddr(rld_addr), .wdata(rld_wdata),
    .idx_wr(idx_wr), .idx_wdata(idx_wdata), .policy(idx_policy), .step(ev_match),
    .idx(idx_now), .val(reload_val)
  );

  tmr_flag_unit u_flags (
    .clk(clk), .rst_n(rst_n), .set_match(ev_match), .set_unf(ev_unf), .set_ovf(ev_ovf),
    .clr(flag_clr), .irq_en(irq_en), .irq_cause(irq_cause), .trig_ev(ev_trig),
    .route(trig_route), .f_match(flag_match), .f_unf(flag_under), .f_ovf(flag_over),
    .irq(irq), .trig(trig)
  );

  assign trig_dma1 = trig[0];
  assign trig_dma2 = trig[1];
  assign trig_uart = trig[2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count   <= '0;
      phase_q <= 1'b1;
    end else if (soft_rst) begin
      count   <= '0;
      phase_q <= 1'b1;
    end else if (cnt_wr) begin
      count   <= cnt_wdata;
    end else if (adv) begin
      count   <= nxt_cnt;
      phase_q <= nxt_phase;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q  <= 1'b0;
      in_reset <= 1'b0;
    end else begin
      in_reset <= soft_rst;
      if (ev_stop)        start_q <= 1'b0;
      else if (start_clr) start_q <= 1'b0;
      else if (start_set) start_q <= 1'b1;
    end
  end

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv && !cnt_wr && !soft_rst) |=> $stable(count)); // R2
  AST_SOFT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (count == '0 && in_reset && !run)); // R12
  AST_SINGLE_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    ev_stop |=> !run); // R6
  AST_STOP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_stop && !cnt_wr && !soft_rst) |=> $stable(count) == 1'b0 || count == $past(nxt_cnt)); // R7

endmodule

// File: tb/span_timer_tb.sv
module span_timer_tb;
  localparam int W = 32;
  localparam logic [W-1:0] MX = '1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic tick = 0, en = 0, sset = 0, sclr = 0, srst = 0, cwr = 0, rwr = 0, iwr = 0, ien = 0;
  logic [1:0] dir = 0, pol = 0, route = 0, ra = 0, iwd = 0;
  logic [2:0] mode = 0, clr = 0, cause = 0;
  logic [W-1:0] match = 0, cwd = 0, rwd = 0;
  logic [W-1:0] count;
  logic run, in_reset, f_m, f_u, f_o, irq, t1, t2, t3;
  logic [1:0] idx_now;

  always #4 clk = ~clk;

  span_timer u_dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .ctl_en(en), .start_set(sset), .start_clr(sclr),
    .soft_rst(srst), .dir_sel(dir), .mode_sel(mode), .match_val(match), .cnt_wr(cwr),
    .cnt_wdata(cwd), .rld_wr(rwr), .rld_addr(ra), .rld_wdata(rwd), .idx_wr(iwr),
    .idx_wdata(iwd), .idx_policy(pol), .flag_clr(clr), .irq_en(ien), .irq_cause(cause),
    .trig_route(route), .count(count), .run(run), .in_reset(in_reset), .idx_now(idx_now),
    .flag_match(f_m), .flag_under(f_u), .flag_over(f_o), .irq(irq),
    .trig_dma1(t1), .trig_dma2(t2), .trig_uart(t3)
  );

  // reference state
  logic [W-1:0] m_cnt = 0;
  logic m_up = 1, m_start = 0, m_inrst = 0, m_fm = 0, m_fu = 0, m_fo = 0;
  logic [1:0] m_idx = 0;
  logic [2:0] m_trig = 0;
  logic [W-1:0] m_rld [4];
  int checks = 0, fails = 0;
  bit done = 0;
  string ctag = "R3";

  task automatic chk(string req, string what, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s act=%0h exp=%0h (dir=%0d mode=%0d)", req, what, act, exp, dir, mode);
    end
  endtask

  task automatic m_step();
    logic adv, up, ovf, unf, term, hit, stp, tev;
    logic [W:0] wide;
    logic [W-1:0] nx, nv;
    adv = tick && en && m_start && !m_inrst && !srst && !cwr;
    if (dir == 2'd1) up = 1'b0;
    else if (dir == 2'd2) up = (m_cnt == MX) ? 1'b0 : (m_cnt == 0) ? 1'b1 : m_up;
    else up = 1'b1;
    wide = up ? {1'b0, m_cnt} + 1 : {1'b0, m_cnt} - 1;
    nx = wide[W-1:0];
    if (dir == 2'd2) begin
      ovf = up && nx == MX; unf = !up && nx == 0; term = ovf || unf;
    end else begin
      ovf = wide[W] && up; unf = wide[W] && !up;
      term = up ? (nx == MX) : (nx == 0);
    end
    hit = (nx == match);
    nv = nx; stp = 0;
    case (mode)
      3'd1: begin tev = term; stp = term; end
      3'd2: begin tev = hit; stp = hit; end
      3'd3: begin tev = term; if (term) nv = m_rld[m_idx]; end
      3'd4: begin tev = hit; if (hit) nv = m_rld[m_idx]; end
      default: tev = ovf || unf;
    endcase
    if (srst) begin m_cnt = 0; m_up = 1; end
    else if (cwr) m_cnt = cwd;
    else if (adv) begin
      m_cnt = nv;
      if (dir == 2'd2) m_up = (nx == MX) ? 1'b0 : (nx == 0) ? 1'b1 : up;
    end
    if (adv && stp) m_start = 0;
    else if (sclr) m_start = 0;
    else if (sset) m_start = 1;
    m_fm = (adv && hit) || (m_fm && !clr[0]);
    m_fu = (adv && unf) || (m_fu && !clr[1]);
    m_fo = (adv && ovf) || (m_fo && !clr[2]);
    if (iwr) m_idx = iwd;
    else if (adv && hit) begin
      if (pol == 2'd1) m_idx = m_idx + 2'd1;
      else if (pol == 2'd2) m_idx = m_idx + 2'd3;
    end
    if (rwr) m_rld[ra] = rwd;
    m_trig = (adv && tev && route != 0) ? (3'b001 << (route - 1)) : 3'b000;
    m_inrst = srst;
  endtask

  task automatic check_all();
    logic ei;
    ei = ien && ((cause == 0 && m_fm) || (cause == 1 && m_fu) || (cause == 2 && m_fo));
    chk(ctag, "count", count, m_cnt);
    chk("R2", "run", W'(run), W'(en && m_start && !m_inrst));
    chk("R12", "in_reset", W'(in_reset), W'(m_inrst));
    chk("R10", "idx_now", W'(idx_now), W'(m_idx));
    chk("R11", "flags", W'({f_o, f_u, f_m}), W'({m_fo, m_fu, m_fm}));
    chk("R13", "irq", W'(irq), W'(ei));
    chk("R14", "trig", W'({t3, t2, t1}), W'(m_trig));
  endtask

  task automatic cyc();
    m_step();
    @(posedge clk);
    @(negedge clk);
    check_all();
    sset = 0; sclr = 0; cwr = 0; rwr = 0; iwr = 0; clr = 0;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired, run hung");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < 4; k++) m_rld[k] = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", "count", count, '0);
    chk("R1", "flags", W'({f_o, f_u, f_m}), '0);
    chk("R1", "idx_now", W'(idx_now), '0);
    chk("R1", "run/in_reset", W'({run, in_reset}), '0);
    chk("R1", "irq/trig", W'({irq, t3, t2, t1}), '0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int d = 0; d < 3; d++) begin
      for (int md = 0; md < 5; md++) begin
        dir = 2'(d); mode = 3'(md);
        pol = 2'((d + md) % 3); route = 2'((d + md) % 4); cause = 3'(md % 4);
        en = 1; ien = 1; tick = 0;
        case (md)
          0: ctag = (d == 0) ? "R3" : (d == 1) ? "R4" : "R5";
          1: ctag = "R6";
          2: ctag = "R7";
          3: ctag = "R8";
          default: ctag = "R9";
        endcase
        srst = 1; cyc(); cyc(); srst = 0;
        for (int k = 0; k < 4; k++) begin
          rwr = 1; ra = 2'(k);
          rwd = (d == 1) ? W'(4 + k) : MX - W'(5 + k);
          cyc();
        end
        match = (d == 1) ? W'(1) : MX - W'(1);
        iwr = 1; iwd = 0; cwr = 1; cwd = (d == 1) ? W'(3) : MX - W'(3); clr = 3'b111;
        cyc();
        sset = 1; cyc();
        for (int i = 0; i < 24; i++) begin
          tick = (i % 4 != 3);
          en = !(i == 5 || i == 6);
          if (i == 10) sset = 1;
          if (i == 12) begin
            cwr = 1;
            cwd = (d == 0) ? MX - W'(2) : (d == 1) ? W'(2) : W'(3);
          end
          if (i == 15) clr = 3'b111;
          if (i == 17) begin iwr = 1; iwd = 2'd3; end
          if (i == 19) sclr = 1;
          cyc();
        end
        tick = 0;
      end
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule